// File: doc/BRIEF.md
# Ramped Stereo Volume Stage with Soft Mute

This block scales a stereo pair of 24-bit two's-complement audio samples by a gain selected through a 7-bit attenuation code. The gain follows a linear law. Code 0 gives unity gain, code 127 gives silence, and every code in between gives a numerator of (127 − code) over 128.

A new code never takes effect at once. The block keeps an applied code that walks toward the written code by one step per fixed interval. The interval is counted in input-sample strobes: 8 strobes in normal-speed mode and 16 in high-speed mode. The mute control reuses the same walk. It drives the applied code to 127 and, when released, back to the stored code. A code written during mute is only stored. The block sits in the sample path at the input rate and takes one strobe per sample period.

Top module: `soft_volume`

## Requirements
- R1: After reset, left_out, right_out, out_valid and busy are all 0. The stored code is 0 and mute is inactive, so samples pass at unity gain.
- R2: While the applied code is 0, each output sample equals the input sample (gain 128/128).
- R3: While the applied code c is in 1..126, each output equals floor(sample × (127 − c) / 128), kept as 24-bit two's complement. For example, code 63 maps −3 to −2.
- R4: While the applied code is 127, both outputs are 0.
- R5: With hs_mode = 0, the applied code moves one step on every 8th fs_tick while busy. A change of n codes therefore finishes on the (8·n)-th strobe after the write.
- R6: With hs_mode = 1, the interval is 16 strobes. A change of n codes finishes on the (16·n)-th strobe.
- R7: The applied code moves by exactly one per step, upward or downward toward the target, and holds once it equals the target.
- R8: While mute is 1, the target is code 127. When mute returns to 0, the applied code walks back to the stored code at the same rate.
- R9: A code written while mute is 1 changes neither the outputs nor busy until mute is released. The applied code then walks to the new code.
- R10: busy is 1 exactly while the applied code differs from the target. It rises in the cycle after a write or mute change that moves the target.
- R11: out_valid and the scaled pair appear in the cycle after fs_tick. They use the applied code that held at that strobe, before any step taken on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_tick | input | 1 | One-cycle strobe per input sample period |
| hs_mode | input | 1 | 1 selects the 16-strobe step interval, 0 the 8-strobe interval |
| code_wr | input | 1 | Write strobe for code_in |
| code_in | input | 7 | Attenuation code (0 = unity, 127 = silence) |
| mute | input | 1 | 1 ramps the gain to zero, 0 ramps it back |
| left_in | input | 24 | Left sample, two's complement, valid with fs_tick |
| right_in | input | 24 | Right sample, two's complement, valid with fs_tick |
| left_out | output | 24 | Scaled left sample |
| right_out | output | 24 | Scaled right sample |
| out_valid | output | 1 | High for one cycle when the scaled pair is updated |
| busy | output | 1 | Applied code differs from the target |

## Verification
Scaled samples are due one clock after their fs_tick. The monitor pops the expected pair on the out_valid cycle and samples it on the falling edge, half a clock after the register updates. Ramp steps take effect on the strobe that completes an interval, and busy follows one clock later. The bench therefore updates its gain model only after the strobe cycle ends and reads busy two falling edges later. It counts strobes until busy drops and compares that count with steps × interval. For a write or mute change, busy is read on the first falling edge after the one-cycle strobe.

// File: rtl/soft_volume_pkg.sv
package soft_volume_pkg;
  localparam int CODE_W   = 7;
  localparam int GAIN_W   = CODE_W + 1;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  // Linear law: code 0 -> full scale, top code -> zero, else (max - code)
  function automatic logic [GAIN_W-1:0] gain_num(input logic [CODE_W-1:0] code);
    logic [GAIN_W-1:0] g;
    if (code == '0)
      g = GAIN_W'(1 << CODE_W);
    else if (code == CODE_W'(CODE_MAX))
      g = '0;
    else
      g = GAIN_W'(CODE_MAX) - GAIN_W'(code);
    return g;
  endfunction
endpackage

// File: rtl/vol_code_store.sv
module vol_code_store
  import soft_volume_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_wr,
  input  logic [CODE_W-1:0] code_in,
  input  logic              mute,
  output logic [CODE_W-1:0] target_code
);
  logic [CODE_W-1:0] stored_q, stored_d;

  always_comb begin
    stored_d = stored_q;
    if (code_wr) stored_d = code_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stored_q <= '0;
    else        stored_q <= stored_d;
  end

  // Mute overrides the stored setting; the stored value survives untouched
  assign target_code = mute ? CODE_W'(CODE_MAX) : stored_q;
endmodule

// File: rtl/vol_ramp.sv
module vol_ramp
  import soft_volume_pkg::*;
#(
  parameter int NORM_STEP = 8,
  parameter int FAST_STEP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_tick,
  input  logic              hs_mode,
  input  logic [CODE_W-1:0] target_code,
  output logic [CODE_W-1:0] applied_code,
  output logic              busy
);
  localparam int LONGEST = (FAST_STEP > NORM_STEP) ? FAST_STEP : NORM_STEP;
  localparam int CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d, limit;
  logic [CODE_W-1:0] app_q, app_d;

  assign limit = hs_mode ? CNT_W'(FAST_STEP - 1) : CNT_W'(NORM_STEP - 1);

  always_comb begin
    app_d = app_q;
    cnt_d = cnt_q;
    if (app_q == target_code) begin
      cnt_d = '0;
    end else if (fs_tick) begin
      if (cnt_q >= limit) begin
        cnt_d = '0;
        app_d = (target_code > app_q) ? app_q + 1'b1 : app_q - 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app_q <= '0;
      cnt_q <= '0;
    end else begin
      app_q <= app_d;
      cnt_q <= cnt_d;
    end
  end

  assign applied_code = app_q;
  assign busy         = (app_q != target_code);
endmodule

// File: rtl/vol_scale.sv
module vol_scale
  import soft_volume_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CHANS  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fs_tick,
  input  logic [CODE_W-1:0]            applied_code,
  input  logic [CHANS-1:0][DATA_W-1:0] samp_in,
  output logic [CHANS-1:0][DATA_W-1:0] samp_out,
  output logic                         out_valid
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;

  logic [GAIN_W-1:0] gain;
  logic              valid_q;

  assign gain = gain_num(applied_code);

  for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
    logic signed [PROD_W-1:0] prod;
    logic [DATA_W-1:0]        res_d, res_q;

    assign prod = $signed(samp_in[ch]) * $signed({1'b0, gain});

    always_comb begin
      res_d = res_q;
      if (fs_tick) res_d = DATA_W'(prod >>> CODE_W);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q <= '0;
      else        res_q <= res_d;
    end

    assign samp_out[ch] = res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= fs_tick;
  end

  assign out_valid = valid_q;
endmodule

// File: rtl/soft_volume.sv
module soft_volume
  import soft_volume_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int NORM_STEP = 8,
  parameter int FAST_STEP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_tick,
  input  logic              hs_mode,
  input  logic              code_wr,
  input  logic [CODE_W-1:0] code_in,
  input  logic              mute,
  input  logic [DATA_W-1:0] left_in,
  input  logic [DATA_W-1:0] right_in,
  output logic [DATA_W-1:0] left_out,
  output logic [DATA_W-1:0] right_out,
  output logic              out_valid,
  output logic              busy
);
  logic [1:0]              rst_sync_q;
  logic                    rst_core_n;
  logic [CODE_W-1:0]       target_code;
  logic [CODE_W-1:0]       applied_code;
  logic [1:0][DATA_W-1:0]  samp_in, samp_out;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  vol_code_store u_store (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .code_wr     (code_wr),
    .code_in     (code_in),
    .mute        (mute),
    .target_code (target_code)
  );

  vol_ramp #(.NORM_STEP(NORM_STEP), .FAST_STEP(FAST_STEP)) u_ramp (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .fs_tick      (fs_tick),
    .hs_mode      (hs_mode),
    .target_code  (target_code),
    .applied_code (applied_code),
    .busy         (busy)
  );

  assign samp_in[0] = left_in;
  assign samp_in[1] = right_in;

  vol_scale #(.DATA_W(DATA_W), .CHANS(2)) u_scale (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .fs_tick      (fs_tick),
    .applied_code (applied_code),
    .samp_in      (samp_in),
    .samp_out     (samp_out),
    .out_valid    (out_valid)
  );

  assign left_out  = samp_out[0];
  assign right_out = samp_out[1];
endmodule

// File: rtl/soft_volume_chk.sv
module soft_volume_chk
  import soft_volume_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              fs_tick,
  input logic              mute,
  input logic [CODE_W-1:0] applied_code,
  input logic              busy,
  input logic [DATA_W-1:0] left_in,
  input logic [DATA_W-1:0] left_out,
  input logic [DATA_W-1:0] right_out,
  input logic              out_valid
);
  p_unit_step_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (applied_code != $past(applied_code)) |->
      ((applied_code == $past(applied_code) + 1'b1) ||
       (applied_code == $past(applied_code) - 1'b1)));

  p_step_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    !fs_tick |=> $stable(applied_code));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    !busy |=> $stable(applied_code));

  p_mute_floor_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mute && !busy) |-> (applied_code == CODE_W'(CODE_MAX)));

  p_valid_after_tick_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    fs_tick |=> out_valid);

  p_no_stray_valid_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    !fs_tick |=> !out_valid);

  p_silence_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (fs_tick && applied_code == CODE_W'(CODE_MAX)) |=> (left_out == '0 && right_out == '0));

  p_unity_pass_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (fs_tick && applied_code == '0) |=> (left_out == $past(left_in)));
endmodule

bind soft_volume soft_volume_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_core_n   (rst_core_n),
  .fs_tick      (fs_tick),
  .mute         (mute),
  .applied_code (applied_code),
  .busy         (busy),
  .left_in      (left_in),
  .left_out     (left_out),
  .right_out    (right_out),
  .out_valid    (out_valid)
);

// File: tb/soft_volume_test.sv
module soft_volume_test;
  logic        clk = 1'b0;
  logic        rst_n, fs_tick, hs_mode, code_wr, mute;
  logic [6:0]  code_in;
  logic [23:0] left_in, right_in, left_out, right_out;
  logic        out_valid, busy;

  always #5 clk = ~clk;

  soft_volume uut (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .hs_mode(hs_mode),
    .code_wr(code_wr), .code_in(code_in), .mute(mute),
    .left_in(left_in), .right_in(right_in),
    .left_out(left_out), .right_out(right_out),
    .out_valid(out_valid), .busy(busy)
  );

  int    checks = 0, failures = 0;
  string phase  = "R1";
  bit    done   = 0;

  // Reference state of the gain walk
  int m_app = 0, m_stored = 0, m_cnt = 0;
  bit m_mute = 0, m_hs = 0;
  int seed = 1;

  typedef struct { logic [23:0] l; logic [23:0] r; } pair_t;
  pair_t sb_q[$];

  function automatic logic [23:0] ref_scale(logic [23:0] s, int code);
    longint g, p;
    if (code == 0)        g = 128;
    else if (code == 127) g = 0;
    else                  g = 127 - code;
    p = longint'($signed(s)) * g;
    return 24'(p >>> 7);
  endfunction

  function automatic int ref_target();
    return m_mute ? 127 : m_stored;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(logic [23:0] l, logic [23:0] r);
    int tgt;
    @(negedge clk);
    left_in = l; right_in = r; fs_tick = 1'b1;
    sb_q.push_back('{ref_scale(l, m_app), ref_scale(r, m_app)});
    @(negedge clk);
    fs_tick = 1'b0;
    tgt = ref_target();
    if (m_app == tgt) m_cnt = 0;
    else if (m_cnt >= (m_hs ? 15 : 7)) begin
      m_cnt = 0;
      m_app = (tgt > m_app) ? m_app + 1 : m_app - 1;
    end else m_cnt++;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [23:0] next_pat();
    seed = seed * 1103515245 + 12345;
    return 24'(seed >>> 5);
  endfunction

  task automatic write_code(int c, bit expect_busy, string req);
    @(negedge clk);
    code_wr = 1'b1; code_in = 7'(c);
    @(negedge clk);
    code_wr = 1'b0;
    m_stored = c;
    chk(busy == expect_busy, req, "busy after write", busy, expect_busy);
  endtask

  task automatic set_mute(bit b, bit expect_busy, string req);
    @(negedge clk);
    mute = b; m_mute = b;
    @(negedge clk);
    chk(busy == expect_busy, req, "busy after mute change", busy, expect_busy);
  endtask

  // Count strobes until busy drops; compare the count and busy each strobe
  task automatic ramp_count(int expected, string req);
    int n = 0;
    do begin
      send(next_pat(), next_pat());
      n++;
      chk(busy == (m_app != ref_target()), "R10", "busy tracks walk", busy, m_app != ref_target());
    end while (busy && n < 4000);
    chk(n == expected, req, "strobes to settle", n, expected);
    chk(m_app == ref_target(), "R7", "walk ends on target", m_app, ref_target());
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb_q.size() == 0) begin
        chk(0, phase, "unexpected out_valid", 1, 0);
      end else begin
        pair_t e;
        e = sb_q.pop_front();
        chk(left_out == e.l, phase, "left_out", longint'($signed(left_out)), longint'($signed(e.l)));
        chk(right_out == e.r, phase, "right_out", longint'($signed(right_out)), longint'($signed(e.r)));
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fs_tick = 1'b0; hs_mode = 1'b0; code_wr = 1'b0;
    mute = 1'b0; code_in = '0; left_in = '0; right_in = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(left_out == 0 && right_out == 0, "R1", "outputs in reset", left_out, 0);
    chk(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    chk(busy == 0, "R1", "busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(busy == 0, "R1", "busy after release", busy, 0);

    // R2: unity gain, extremes included
    phase = "R2";
    send(24'h7FFFFF, 24'h800000);
    send(24'hFFFFFD, 24'h000001);
    send(next_pat(), next_pat());

    // R5 / R10: normal-mode walk 0 -> 3 takes 24 strobes
    phase = "R5";
    write_code(3, 1, "R10");
    ramp_count(24, "R5");

    // R3: walk up to 63, then check the halving with floor rounding
    phase = "R3";
    write_code(63, 1, "R10");
    ramp_count(60 * 8, "R5");
    send(24'hFFFFFD, 24'h000003);
    send(24'h7FFFFF, 24'h800000);
    send(next_pat(), next_pat());
    chk(m_app == 63, "R3", "settled code", m_app, 63);

    // R6 / R7: high-speed interval, walking downward 63 -> 0
    phase = "R6";
    hs_mode = 1'b1; m_hs = 1'b1;
    write_code(0, 1, "R10");
    ramp_count(63 * 16, "R6");
    send(24'h123456, 24'hEDCBA9);
    hs_mode = 1'b0; m_hs = 1'b0;

    // R8 / R4: mute walks 0 -> 127 at the normal rate
    phase = "R8";
    set_mute(1, 1, "R8");
    ramp_count(127 * 8, "R8");
    phase = "R4";
    send(24'h7FFFFF, 24'h800000);
    send(next_pat(), next_pat());

    // R9: write while muted is stored only
    phase = "R9";
    write_code(10, 0, "R9");
    for (int i = 0; i < 20; i++) begin
      send(next_pat(), next_pat());
      chk(busy == 0, "R9", "busy stays low while muted", busy, 0);
    end
    set_mute(0, 1, "R9");
    ramp_count(117 * 8, "R9");
    phase = "R3";
    send(24'h400000, 24'hC00000);

    // R4: unmuted write of 127 reaches silence
    phase = "R4";
    write_code(127, 1, "R10");
    ramp_count(117 * 8, "R4");
    send(24'h7FFFFF, 24'h800000);

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R11", "scoreboard drained", sb_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule